// File: doc/BRIEF.md
# Bidirectional Port and Edge-Interrupt Peripheral

This block is a register-mapped I/O peripheral for a small 16-bit microcontroller. It serves three 8-bit bidirectional ports and one 8-bit input-only scan port. Software sets each bidirectional bit as a high-impedance input or as a driven output. It reads pin levels and writes output latches over a simple single-cycle address/data bus. The block drives the pad output-enable and output-data lines directly.

A small set of pins is watched for edges. On the second bidirectional port (port 1), bits 2 and 4 raise requests on rising edges and bits 3 and 5 on falling edges. Any falling bit of the scan port raises a shared key request. A digital comparator result, which stands for the analog comparison of port-1 bit 5 against bit 4, has a rising-edge request of its own. While the comparator is enabled it takes over port-1 bits 4 and 5. All inputs pass through a synchronizer first. An edge is accepted only if the old level was held for a minimum number of synchronized cycles. Accepted edges latch into a flag register, and a mask register gates the flags onto the request lines.

Top module: `pio_irq_unit`

## Requirements
- R1: After reset every output enable is 0, every pullup enable is 0, the flag register, mask register and comparator enable read 0, and the request lines are 0.
- R2: Bidirectional port p (p = 0,1,2) has its output latch at address 0x10+8p and its direction register at 0x14+8p. A direction bit of 1 makes the bit an output: its output enable is 1 and its output data equals the latch bit.
- R3: A read of a port's latch address returns the latch bit for output bits and the synchronized pin level for input bits. A read of the direction address returns the direction register.
- R4: A read of address 0x28 returns the synchronized scan-port pins. Address 0x2C is a read/write pullup-enable register that drives the scan-port pullup outputs bit for bit.
- R5: On port 1, a rising edge on bit 2 sets flag bit 0, a falling edge on bit 3 sets flag bit 1, a rising edge on bit 4 sets flag bit 2 and a falling edge on bit 5 sets flag bit 3. The opposite edges set nothing.
- R6: A falling edge on any scan-port bit sets flag bit 4. Rising edges set nothing.
- R7: An edge is accepted only when the synchronized pin held its previous level for at least MIN_HOLD (default 2) cycles. A level held for fewer cycles produces no flag.
- R8: Bit 0 of the control register at 0x2D enables the comparator. While it is set, output enables of port-1 bits 4 and 5 are 0, edges on those pins set no flag, and a rising edge of the comparator input sets flag bit 5. While it is clear, the comparator input sets nothing.
- R9: The mask register is at 0x38 and the flag register at 0x39, each 6 bits wide. The request lines equal flag AND mask. A masked flag stays pending.
- R10: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. An accepted edge in the same cycle as a clear of its bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle; 0 when not reading |
| gp0_in | input | 8 | Port 0 pin levels |
| gp0_out | output | 8 | Port 0 output data |
| gp0_oe | output | 8 | Port 0 output enables |
| gp1_in | input | 8 | Port 1 pin levels |
| gp1_out | output | 8 | Port 1 output data |
| gp1_oe | output | 8 | Port 1 output enables |
| gp2_in | input | 8 | Port 2 pin levels |
| gp2_out | output | 8 | Port 2 output data |
| gp2_oe | output | 8 | Port 2 output enables |
| key_in | input | 8 | Scan-port pin levels |
| key_pu | output | 8 | Scan-port pullup enables |
| cmp_in | input | 1 | Digital comparator result |
| irq_req | output | 6 | Masked interrupt requests |

## Verification
The bench builds the block with SYNC_STAGES = 2 and MIN_HOLD = 2. With these values, a level held for one cycle falls just under the acceptance threshold and a two-cycle level sits exactly on it, so both sides of the boundary are exercised. The fixed three-cycle path from pin to flag also lets the bench line an accepted edge up with a flag clear in the very same cycle, which checks the set-over-clear priority directly.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_BIDIR = 3;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 8;
    localparam int IRQ_N     = 6;

    // register addresses
    localparam logic [ADDR_W-1:0] A_PORT_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] PORT_STRIDE = 8'h08;
    localparam logic [ADDR_W-1:0] DIR_OFS     = 8'h04;
    localparam logic [ADDR_W-1:0] A_KEY_LVL   = 8'h28;
    localparam logic [ADDR_W-1:0] A_KEY_PU    = 8'h2C;
    localparam logic [ADDR_W-1:0] A_CTRL      = 8'h2D;
    localparam logic [ADDR_W-1:0] A_MASK      = 8'h38;
    localparam logic [ADDR_W-1:0] A_FLAG      = 8'h39;

    // watched pins of port 1: WATCH_N consecutive bits from WATCH_LO
    localparam int WATCH_LO = 2;
    localparam int WATCH_N  = 4;
    localparam int CMP_LO   = 4;
    localparam int CMP_HI   = 5;

    // flag bit positions
    localparam int IRQ_D2  = 0;
    localparam int IRQ_D3  = 1;
    localparam int IRQ_D4  = 2;
    localparam int IRQ_D5  = 3;
    localparam int IRQ_KEY = 4;
    localparam int IRQ_CMP = 5;

    typedef logic [PORT_W-1:0] byte_t;

    typedef struct packed {
        byte_t [NUM_BIDIR-1:0] dat;
        byte_t [NUM_BIDIR-1:0] dir;
        byte_t                 pu;
        logic                  cmp_en;
        logic [IRQ_N-1:0]      mask;
        logic [IRQ_N-1:0]      flag;
    } pio_regs_t;

    function automatic logic [ADDR_W-1:0] dat_addr(input int p);
        return A_PORT_BASE + ADDR_W'(p) * PORT_STRIDE;
    endfunction

    function automatic logic [ADDR_W-1:0] dir_addr(input int p);
        return dat_addr(p) + DIR_OFS;
    endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pio_edge.sv
module pio_edge #(
    parameter int MIN_HOLD = 2,
    parameter bit RISING   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fire
);
    localparam int CW = $clog2(MIN_HOLD + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] held;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (lvl != st_q.prev) begin
            // held counts samples of the old level, saturating at MIN_HOLD
            fire      = (st_q.held >= CW'(MIN_HOLD)) && (lvl == RISING);
            st_d.prev = lvl;
            st_d.held = CW'(1);
        end else if (st_q.held < CW'(MIN_HOLD)) begin
            st_d.held = st_q.held + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit
    import pio_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HOLD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [PORT_W-1:0] gp0_in,
    output logic [PORT_W-1:0] gp0_out,
    output logic [PORT_W-1:0] gp0_oe,
    input  logic [PORT_W-1:0] gp1_in,
    output logic [PORT_W-1:0] gp1_out,
    output logic [PORT_W-1:0] gp1_oe,
    input  logic [PORT_W-1:0] gp2_in,
    output logic [PORT_W-1:0] gp2_out,
    output logic [PORT_W-1:0] gp2_oe,
    input  logic [PORT_W-1:0] key_in,
    output logic [PORT_W-1:0] key_pu,
    input  logic              cmp_in,
    output logic [IRQ_N-1:0]  irq_req
);
    localparam int SYN_W = NUM_BIDIR * PORT_W + PORT_W + 1;

    // ---------------- input synchronizer ----------------
    logic [SYN_W-1:0]       raw_in, syn_all;
    byte_t [NUM_BIDIR-1:0]  syn_pin;
    byte_t                  syn_key;
    logic                   syn_cmp;

    assign raw_in = {cmp_in, key_in, gp2_in, gp1_in, gp0_in};

    pio_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_all)
    );

    assign syn_pin = syn_all[NUM_BIDIR*PORT_W-1:0];
    assign syn_key = syn_all[NUM_BIDIR*PORT_W +: PORT_W];
    assign syn_cmp = syn_all[SYN_W-1];

    // ---------------- register state ----------------
    pio_regs_t st_d, st_q;

    // effective output enables: comparator takes over two port-1 pins
    byte_t [NUM_BIDIR-1:0] oe_eff;
    always_comb begin
        oe_eff = st_q.dir;
        if (st_q.cmp_en) begin
            oe_eff[1][CMP_LO] = 1'b0;
            oe_eff[1][CMP_HI] = 1'b0;
        end
    end

    // ---------------- edge detectors ----------------
    logic [WATCH_N-1:0] pin_fire;
    logic [PORT_W-1:0]  key_fire;
    logic               cmp_fire;

    generate
        for (genvar k = 0; k < WATCH_N; k++) begin : g_watch
            // even offsets watch rising edges, odd offsets falling edges
            pio_edge #(.MIN_HOLD(MIN_HOLD), .RISING((k % 2) == 0)) u_pin (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl   (syn_pin[1][WATCH_LO+k]),
                .fire  (pin_fire[k])
            );
        end
        for (genvar k = 0; k < PORT_W; k++) begin : g_key
            pio_edge #(.MIN_HOLD(MIN_HOLD), .RISING(1'b0)) u_key (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl   (syn_key[k]),
                .fire  (key_fire[k])
            );
        end
    endgenerate

    pio_edge #(.MIN_HOLD(MIN_HOLD), .RISING(1'b1)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (syn_cmp),
        .fire  (cmp_fire)
    );

    logic [IRQ_N-1:0] src_set;
    always_comb begin
        src_set          = '0;
        src_set[IRQ_D2]  = pin_fire[0];
        src_set[IRQ_D3]  = pin_fire[1];
        src_set[IRQ_D4]  = pin_fire[2] & ~st_q.cmp_en;
        src_set[IRQ_D5]  = pin_fire[3] & ~st_q.cmp_en;
        src_set[IRQ_KEY] = |key_fire;
        src_set[IRQ_CMP] = cmp_fire & st_q.cmp_en;
    end

    // ---------------- register writes ----------------
    logic             wr_en;
    byte_t            wbyte;
    logic [IRQ_N-1:0] flag_clr;

    assign wr_en = bus_sel & bus_wr;
    assign wbyte = bus_wdata[PORT_W-1:0];

    always_comb begin
        st_d     = st_q;
        flag_clr = '0;
        if (wr_en) begin
            for (int p = 0; p < NUM_BIDIR; p++) begin
                if (bus_addr == dat_addr(p)) st_d.dat[p] = wbyte;
                if (bus_addr == dir_addr(p)) st_d.dir[p] = wbyte;
            end
            case (bus_addr)
                A_KEY_PU: st_d.pu     = wbyte;
                A_CTRL:   st_d.cmp_en = bus_wdata[0];
                A_MASK:   st_d.mask   = bus_wdata[IRQ_N-1:0];
                A_FLAG:   flag_clr    = bus_wdata[IRQ_N-1:0];
                default:  ;
            endcase
        end
        // a new edge wins over a clear in the same cycle
        st_d.flag = (st_q.flag & ~flag_clr) | src_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- register reads ----------------
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int p = 0; p < NUM_BIDIR; p++) begin
                if (bus_addr == dat_addr(p))
                    bus_rdata[PORT_W-1:0] = (st_q.dat[p] & oe_eff[p]) | (syn_pin[p] & ~oe_eff[p]);
                if (bus_addr == dir_addr(p))
                    bus_rdata[PORT_W-1:0] = st_q.dir[p];
            end
            case (bus_addr)
                A_KEY_LVL: bus_rdata[PORT_W-1:0] = syn_key;
                A_KEY_PU:  bus_rdata[PORT_W-1:0] = st_q.pu;
                A_CTRL:    bus_rdata[0]          = st_q.cmp_en;
                A_MASK:    bus_rdata[IRQ_N-1:0]  = st_q.mask;
                A_FLAG:    bus_rdata[IRQ_N-1:0]  = st_q.flag;
                default:   ;
            endcase
        end
    end

    // ---------------- pad and request outputs ----------------
    assign gp0_out = st_q.dat[0];
    assign gp1_out = st_q.dat[1];
    assign gp2_out = st_q.dat[2];
    assign gp0_oe  = oe_eff[0];
    assign gp1_oe  = oe_eff[1];
    assign gp2_oe  = oe_eff[2];
    assign key_pu  = st_q.pu;
    assign irq_req = st_q.flag & st_q.mask;
endmodule

// File: rtl/pio_irq_chk.sv
module pio_irq_chk
    import pio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [PORT_W-1:0] gp0_out,
    input logic [PORT_W-1:0] gp0_oe,
    input logic [PORT_W-1:0] gp1_oe,
    input logic [PORT_W-1:0] gp2_oe,
    input logic [PORT_W-1:0] key_pu,
    input logic [IRQ_N-1:0]  irq_req,
    input logic              cmp_en,
    input logic [IRQ_N-1:0]  flag_q
);
    logic wr_flag, wr_mask, wr_dat0;
    assign wr_flag = bus_sel && bus_wr && (bus_addr == A_FLAG);
    assign wr_mask = bus_sel && bus_wr && (bus_addr == A_MASK);
    assign wr_dat0 = bus_sel && bus_wr && (bus_addr == dat_addr(0));

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (gp0_oe == '0 && gp1_oe == '0 && gp2_oe == '0 &&
                           key_pu == '0 && irq_req == '0));

    p_out_tracks_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dat0 |=> (gp0_out == $past(bus_wdata[PORT_W-1:0])));

    p_cmp_owns_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> (gp1_oe[CMP_HI:CMP_LO] == 2'b00));

    p_mask_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && bus_wdata[IRQ_N-1:0] == '0) |=> (irq_req == '0));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flag_q) & ~flag_q)) |->
            ($past(wr_flag) &&
             ((($past(flag_q) & ~flag_q) & ~$past(bus_wdata[IRQ_N-1:0])) == '0)));
endmodule

bind pio_irq_unit pio_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .gp0_out   (gp0_out),
    .gp0_oe    (gp0_oe),
    .gp1_oe    (gp1_oe),
    .gp2_oe    (gp2_oe),
    .key_pu    (key_pu),
    .irq_req   (irq_req),
    .cmp_en    (st_q.cmp_en),
    .flag_q    (st_q.flag)
);

// File: tb/sim_pio_irq_unit.sv
module sim_pio_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  gp0_in = 8'h00, gp1_in = 8'h28, gp2_in = 8'h00, key_in = 8'hFF;
    logic [7:0]  gp0_out, gp0_oe, gp1_out, gp1_oe, gp2_out, gp2_oe, key_pu;
    logic        cmp_in = 1'b0;
    logic [5:0]  irq_req;

    always #10 clk = ~clk;

    pio_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gp0_in(gp0_in), .gp0_out(gp0_out), .gp0_oe(gp0_oe),
        .gp1_in(gp1_in), .gp1_out(gp1_out), .gp1_oe(gp1_oe),
        .gp2_in(gp2_in), .gp2_out(gp2_out), .gp2_oe(gp2_oe),
        .key_in(key_in), .key_pu(key_pu), .cmp_in(cmp_in), .irq_req(irq_req)
    );

    // observed signal selectors
    localparam int K_RD = 0, K_OUT0 = 1, K_OE0 = 2, K_OE1 = 3, K_OE2 = 4,
                   K_PU = 5, K_IRQ = 6, K_OUT2 = 7;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    logic  mon_go = 1'b0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    function automatic logic [15:0] observe(input int kind);
        case (kind)
            K_RD:    return bus_rdata;
            K_OUT0:  return {8'h00, gp0_out};
            K_OE0:   return {8'h00, gp0_oe};
            K_OE1:   return {8'h00, gp1_oe};
            K_OE2:   return {8'h00, gp2_oe};
            K_PU:    return {8'h00, key_pu};
            K_IRQ:   return {10'h000, irq_req};
            K_OUT2:  return {8'h00, gp2_out};
            default: return 16'hxxxx;
        endcase
    endfunction

    // monitor: samples mid-cycle after the rising edge
    always @(posedge clk) begin
        #5;
        if (mon_go && q.size() > 0) begin
            item_t it;
            logic [15:0] got;
            it  = q.pop_front();
            got = observe(it.kind);
            n_chk++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        it.kind = K_RD; it.exp = e; it.tag = tag;
        q.push_back(it);
        mon_go = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; mon_go = 1'b0;
    endtask

    task automatic expect_pin(input int kind, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
        mon_go = 1'b1;
        @(negedge clk);
        mon_go = 1'b0;
    endtask

    task automatic clear_flags();
        bus_write(8'h39, 16'h003F);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(5);

        // R1: reset state
        expect_pin(K_OE0, 16'h0000, "R1 gp0_oe");
        expect_pin(K_OE1, 16'h0000, "R1 gp1_oe");
        expect_pin(K_OE2, 16'h0000, "R1 gp2_oe");
        expect_pin(K_PU,  16'h0000, "R1 key_pu");
        expect_pin(K_IRQ, 16'h0000, "R1 irq_req");
        expect_read(8'h14, 16'h0000, "R1 dir0");
        expect_read(8'h39, 16'h0000, "R1 flag");
        expect_read(8'h38, 16'h0000, "R1 mask");
        expect_read(8'h2D, 16'h0000, "R1 ctrl");

        // R2 / R3: direction, output data and mixed readback
        bus_write(8'h10, 16'h00A5);
        bus_write(8'h14, 16'h000F);
        gp0_in = 8'h3C;
        expect_pin(K_OUT0, 16'h00A5, "R2 gp0_out");
        expect_pin(K_OE0,  16'h000F, "R2 gp0_oe");
        idle(3);
        expect_read(8'h10, 16'h0035, "R3 gp0 mixed read");
        expect_read(8'h14, 16'h000F, "R3 dir0 read");
        bus_write(8'h24, 16'h00FF);
        bus_write(8'h20, 16'h005A);
        expect_pin(K_OE2,  16'h00FF, "R2 gp2_oe");
        expect_pin(K_OUT2, 16'h005A, "R2 gp2_out");
        expect_read(8'h20, 16'h005A, "R3 gp2 output read");

        // R4: scan port level and pullups
        expect_read(8'h28, 16'h00FF, "R4 key level");
        bus_write(8'h2C, 16'h0081);
        expect_pin(K_PU, 16'h0081, "R4 key_pu");
        expect_read(8'h2C, 16'h0081, "R4 pullup read");

        // R5: watched port-1 edges
        bus_write(8'h38, 16'h003F);
        gp1_in = 8'h2C; idle(4);
        expect_read(8'h39, 16'h0001, "R5 bit2 rise");
        expect_pin(K_IRQ, 16'h0001, "R9 irq bit2");
        clear_flags();
        gp1_in = 8'h24; idle(4);
        expect_read(8'h39, 16'h0002, "R5 bit3 fall");
        clear_flags();
        gp1_in = 8'h2C; idle(4);
        expect_read(8'h39, 16'h0000, "R5 bit3 rise ignored");
        gp1_in = 8'h28; idle(4);
        expect_read(8'h39, 16'h0000, "R5 bit2 fall ignored");
        gp1_in = 8'h38; idle(4);
        expect_read(8'h39, 16'h0004, "R5 bit4 rise");
        clear_flags();
        gp1_in = 8'h18; idle(4);
        expect_read(8'h39, 16'h0008, "R5 bit5 fall");
        clear_flags();
        gp1_in = 8'h28; idle(4);
        expect_read(8'h39, 16'h0000, "R5 bit4 fall bit5 rise ignored");

        // R6: scan-port falling edges
        key_in = 8'hFB; idle(4);
        expect_read(8'h39, 16'h0010, "R6 key fall");
        clear_flags();
        key_in = 8'hFF; idle(4);
        expect_read(8'h39, 16'h0000, "R6 key rise ignored");

        // R7: minimum hold before an edge
        gp1_in = 8'h2C; idle(4);
        clear_flags();
        @(negedge clk); gp1_in = 8'h28;
        @(negedge clk); gp1_in = 8'h2C;
        idle(4);
        expect_read(8'h39, 16'h0000, "R7 one-cycle low rejected");
        @(negedge clk); gp1_in = 8'h28;
        @(negedge clk);
        @(negedge clk); gp1_in = 8'h2C;
        idle(4);
        expect_read(8'h39, 16'h0001, "R7 two-cycle low accepted");
        clear_flags();

        // R10: write-one-to-clear and set priority
        gp1_in = 8'h28; idle(4);
        key_in = 8'hFE; idle(4);
        key_in = 8'hFF; idle(4);
        expect_read(8'h39, 16'h0010, "R10 setup key flag");
        @(negedge clk); gp1_in = 8'h2C;
        @(negedge clk);
        bus_write(8'h39, 16'h0011);
        expect_read(8'h39, 16'h0001, "R10 edge wins over clear");
        bus_write(8'h39, 16'h0000);
        expect_read(8'h39, 16'h0001, "R10 zero write keeps flag");

        // R9: masking
        expect_pin(K_IRQ, 16'h0001, "R9 unmasked request");
        bus_write(8'h38, 16'h003E);
        expect_pin(K_IRQ, 16'h0000, "R9 masked request");
        expect_read(8'h39, 16'h0001, "R9 masked flag pending");
        bus_write(8'h38, 16'h003F);
        clear_flags();
        gp1_in = 8'h28; idle(4);

        // R8: comparator mode
        bus_write(8'h1C, 16'h00FF);
        expect_pin(K_OE1, 16'h00FF, "R8 gp1_oe before enable");
        bus_write(8'h2D, 16'h0001);
        expect_pin(K_OE1, 16'h00CF, "R8 gp1_oe comparator pins released");
        expect_read(8'h2D, 16'h0001, "R8 ctrl read");
        gp1_in = 8'h08; idle(4);
        expect_read(8'h39, 16'h0000, "R8 bit5 fall suppressed");
        gp1_in = 8'h28; idle(4);
        cmp_in = 1'b1; idle(4);
        expect_read(8'h39, 16'h0020, "R8 comparator rise");
        expect_pin(K_IRQ, 16'h0020, "R8 comparator request");
        clear_flags();
        bus_write(8'h2D, 16'h0000);
        cmp_in = 1'b0; idle(4);
        cmp_in = 1'b1; idle(4);
        expect_read(8'h39, 16'h0000, "R8 comparator disabled");
        bus_write(8'h1C, 16'h0000);

        idle(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule